// File: doc/BRIEF.md
# Data Cache Access Controller

This block sits in front of a small direct-mapped data cache and decides, for every incoming access, whether it is a hit, a miss, or must be turned away for lack of resources. It tracks a state per line (invalid, valid, modified, or waiting for a line read). Outstanding line reads are kept in a table of pending blocks that later misses to the same block can join. Requests for lower memory go into a miss queue, which can take up to three new entries in one cycle: a write, a line read and a writeback.

Three configuration inputs set the policy. One selects write-through. One marks the cache as private. One selects allocation on write misses. Before it commits to an access, the controller checks that the miss queue has enough free slots for the worst case of that access. If it does not, it answers with a reservation failure and changes nothing. A fill input returns a line from memory, frees the matching pending entry and makes the line usable. The line is made modified if an atomic access was waiting on it.

Top module: `dcache_access_ctrl`

## Requirements
- R1: After reset every line is invalid, the miss queue is empty (`mem_valid` low) and `resp_valid` is low, so the first read of any address is a miss.
- R2: Each accepted request cycle yields `resp_valid` high on the next cycle with `resp_code` 2'b00 for hit, 2'b01 for miss, 2'b10 for reservation fail; a fail changes no line, pending entry or queue.
- R3: A read that matches a valid or modified line is a hit and queues nothing; if it is atomic the line becomes modified.
- R4: A write hit is forwarded as one write request (`mem_kind` 2'b01, requested address and byte count) and the line becomes invalid when write-through is set, or when the cache is private and the write is global; with no free queue slot it fails instead.
- R5: Any other write hit is a hit, queues nothing and makes the line modified.
- R6: A write miss without write allocation needs one free slot, queues one write request, answers miss and leaves the line untouched.
- R7: A write miss with write allocation needs three free slots and a usable pending entry; it queues the write, then, unless it joins a pending block, a line read and then a writeback if the victim line was modified.
- R8: A read miss needs two free slots; unless it joins a pending block it queues a line read and then, if the victim line was modified, a writeback (`mem_kind` 2'b11, victim line address, full line size).
- R9: A miss to a block already pending joins its entry (at most MSHR_MERGE requests per entry) and queues no line read. A miss to a new block needs a free entry among MSHR_N. A miss to a line waiting for a different block fails.
- R10: A line read (`mem_kind` 2'b10) uses the line-aligned address and the full line size (2^OFF_W bytes), whatever the requested size.
- R11: The queue head is shown on the memory outputs; at most one entry leaves per cycle, and only when `mem_full` is low, otherwise the head is held unchanged.
- R12: A fill makes its waiting line valid, or modified if an atomic read joined that entry, and frees the entry. A request in the same cycle as a fill is answered with reservation fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_write_through | input | 1 | Write hits are forwarded and invalidate the line |
| cfg_private | input | 1 | Cache is private to one core; global write hits are forwarded |
| cfg_write_alloc | input | 1 | Write misses allocate the line |
| req_valid | input | 1 | Access request present |
| req_addr | input | ADDR_W | Byte address |
| req_write | input | 1 | Access is a write |
| req_atomic | input | 1 | Access is an atomic read |
| req_global | input | 1 | Access targets global rather than local space |
| req_bytes | input | OFF_W+1 | Requested byte count |
| resp_valid | output | 1 | Response present (one cycle after request) |
| resp_code | output | 2 | 00 hit, 01 miss, 10 reservation fail |
| fill_valid | input | 1 | A line returns from memory |
| fill_addr | input | ADDR_W | Address of the returning line |
| mem_valid | output | 1 | Miss queue head is valid |
| mem_kind | output | 2 | 01 write, 10 line read, 11 writeback |
| mem_addr | output | ADDR_W | Address of the head request |
| mem_bytes | output | OFF_W+1 | Byte count of the head request |
| mem_full | input | 1 | Memory port cannot accept this cycle |

## Verification
The assertions assume that a fill names a block that has an outstanding pending entry, and that each such block is filled once. The stimulus keeps within this by filling only addresses whose line read it issued itself and has not yet filled. The assertions also assume that atomic accesses arrive as reads. Every request the bench makes keeps the write and atomic flags apart.

// File: rtl/dcac_pkg.sv
package dcac_pkg;

    // most entries one access can put into the miss queue in one cycle
    localparam int MAX_PUSH = 3;

    typedef enum logic [1:0] {
        LN_INV  = 2'b00,
        LN_VAL  = 2'b01,
        LN_MOD  = 2'b10,
        LN_PEND = 2'b11
    } line_st_e;

    typedef enum logic [1:0] {
        RSP_HIT  = 2'b00,
        RSP_MISS = 2'b01,
        RSP_FAIL = 2'b10
    } rsp_e;

    typedef enum logic [1:0] {
        MK_NONE  = 2'b00,
        MK_WRITE = 2'b01,
        MK_READ  = 2'b10,
        MK_WBACK = 2'b11
    } mreq_kind_e;

    function automatic logic line_usable(line_st_e st);
        return (st == LN_VAL) || (st == LN_MOD);
    endfunction

endpackage

// File: rtl/dcac_tag_store.sv
module dcac_tag_store
    import dcac_pkg::*;
#(
    parameter int IDX_W = 3,
    parameter int TAG_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output line_st_e         rd_st,
    input  logic             acc_we,
    input  logic [TAG_W-1:0] acc_tag,
    input  line_st_e         acc_st,
    input  logic [IDX_W-1:0] f_idx,
    output logic [TAG_W-1:0] f_tag,
    output line_st_e         f_st,
    input  logic             fill_we,
    input  line_st_e         fill_st
);
    localparam int SETS = 1 << IDX_W;

    logic [TAG_W-1:0] tag_q [SETS];
    line_st_e         st_q  [SETS];

    assign rd_tag = tag_q[rd_idx];
    assign rd_st  = st_q[rd_idx];
    assign f_tag  = tag_q[f_idx];
    assign f_st   = st_q[f_idx];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[s]  <= LN_INV;
                tag_q[s] <= '0;
            end else if (acc_we && rd_idx == IDX_W'(s)) begin
                st_q[s]  <= acc_st;
                tag_q[s] <= acc_tag;
            end else if (fill_we && f_idx == IDX_W'(s)) begin
                st_q[s]  <= fill_st;
            end
        end
    end

    // a fill only ever completes a line that is waiting
    p_fill_waiting_r12: assert property (@(posedge clk) disable iff (rst)
        fill_we |-> f_st == LN_PEND);

endmodule

// File: rtl/dcac_mshr.sv
module dcac_mshr #(
    parameter int N     = 4,
    parameter int MAXM  = 2,
    parameter int BLK_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [BLK_W-1:0] probe_blk,
    output logic             probe_hit,
    output logic             can_merge,
    output logic             can_new,
    input  logic             add_en,
    input  logic             add_atomic,
    input  logic             rel_en,
    input  logic [BLK_W-1:0] rel_blk,
    output logic             rel_found,
    output logic             rel_atomic
);
    localparam int CNT_W = $clog2(MAXM + 1);
    localparam int IW    = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]     v_q, at_q, hit_vec, rel_vec;
    logic [BLK_W-1:0] blk_q [N];
    logic [CNT_W-1:0] cnt_q [N];
    logic [IW-1:0]    hit_idx, free_idx, rel_idx;
    logic             any_free;

    for (genvar e = 0; e < N; e++) begin : g_match
        assign hit_vec[e] = v_q[e] && (blk_q[e] == probe_blk);
        assign rel_vec[e] = v_q[e] && (blk_q[e] == rel_blk);
    end

    always_comb begin
        hit_idx  = '0;
        rel_idx  = '0;
        free_idx = '0;
        any_free = 1'b0;
        for (int e = N - 1; e >= 0; e--) begin
            if (hit_vec[e]) hit_idx = IW'(e);
            if (rel_vec[e]) rel_idx = IW'(e);
            if (!v_q[e]) begin
                free_idx = IW'(e);
                any_free = 1'b1;
            end
        end
    end

    assign probe_hit  = |hit_vec;
    assign can_merge  = probe_hit && (cnt_q[hit_idx] < CNT_W'(MAXM));
    assign can_new    = !probe_hit && any_free;
    assign rel_found  = |rel_vec;
    assign rel_atomic = rel_found && at_q[rel_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q  <= '0;
            at_q <= '0;
            for (int e = 0; e < N; e++) begin
                blk_q[e] <= '0;
                cnt_q[e] <= '0;
            end
        end else begin
            if (rel_en && rel_found) begin
                v_q[rel_idx]  <= 1'b0;
                at_q[rel_idx] <= 1'b0;
            end
            if (add_en && probe_hit) begin
                cnt_q[hit_idx] <= cnt_q[hit_idx] + CNT_W'(1);
                if (add_atomic) at_q[hit_idx] <= 1'b1;
            end else if (add_en) begin
                v_q[free_idx]   <= 1'b1;
                blk_q[free_idx] <= probe_blk;
                cnt_q[free_idx] <= CNT_W'(1);
                at_q[free_idx]  <= add_atomic;
            end
        end
    end

    p_add_legal_r9: assert property (@(posedge clk) disable iff (rst)
        add_en |-> (can_merge || can_new));
    p_fill_pending_r12: assert property (@(posedge clk) disable iff (rst)
        rel_en |-> rel_found);

endmodule

// File: rtl/dcac_miss_fifo.sv
module dcac_miss_fifo
    import dcac_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int W     = 23
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [1:0]                       push_n,
    input  logic [MAX_PUSH-1:0][W-1:0]       push_data,
    input  logic                             pop,
    output logic [W-1:0]                     head,
    output logic                             nonempty,
    output logic [$clog2(DEPTH+1)-1:0]       free_cnt
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;

    assign head     = mem_q[rd_q];
    assign nonempty = (cnt_q != '0);
    assign free_cnt = CNT_W'(DEPTH) - cnt_q;

    always_ff @(posedge clk) begin
        for (int k = 0; k < MAX_PUSH; k++) begin
            if (2'(k) < push_n) mem_q[wr_q + PTR_W'(k)] <= push_data[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            wr_q  <= wr_q + PTR_W'(push_n);
            rd_q  <= rd_q + PTR_W'(pop);
            cnt_q <= cnt_q + CNT_W'(push_n) - CNT_W'(pop);
        end
    end

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        CNT_W'(push_n) <= free_cnt);
    p_no_underflow_r11: assert property (@(posedge clk) disable iff (rst)
        pop |-> nonempty);
    p_head_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (nonempty && !pop) |=> $stable(head));

endmodule

// File: rtl/dcache_access_ctrl.sv
module dcache_access_ctrl
    import dcac_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int OFF_W      = 4,
    parameter int IDX_W      = 3,
    parameter int MQ_DEPTH   = 8,
    parameter int MSHR_N     = 4,
    parameter int MSHR_MERGE = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_write_through,
    input  logic              cfg_private,
    input  logic              cfg_write_alloc,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_atomic,
    input  logic              req_global,
    input  logic [OFF_W:0]    req_bytes,
    output logic              resp_valid,
    output logic [1:0]        resp_code,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    output logic              mem_valid,
    output logic [1:0]        mem_kind,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [OFF_W:0]    mem_bytes,
    input  logic              mem_full
);
    localparam int BLK_W      = ADDR_W - OFF_W;
    localparam int TAG_W      = BLK_W - IDX_W;
    localparam int SIZE_W     = OFF_W + 1;
    localparam int LINE_BYTES = 1 << OFF_W;
    localparam int FREE_W     = $clog2(MQ_DEPTH + 1);

    typedef struct packed {
        mreq_kind_e        kind;
        logic [ADDR_W-1:0] addr;
        logic [SIZE_W-1:0] bytes;
    } mreq_t;
    localparam int MREQ_W = $bits(mreq_t);

    // address split
    logic [BLK_W-1:0] req_blk, fill_blk;
    logic [IDX_W-1:0] req_idx, fill_idx;
    logic [TAG_W-1:0] req_tag, fill_tag;
    assign req_blk  = req_addr[ADDR_W-1:OFF_W];
    assign req_idx  = req_blk[IDX_W-1:0];
    assign req_tag  = req_blk[BLK_W-1:IDX_W];
    assign fill_blk = fill_addr[ADDR_W-1:OFF_W];
    assign fill_idx = fill_blk[IDX_W-1:0];
    assign fill_tag = fill_blk[BLK_W-1:IDX_W];

    // line state
    logic [TAG_W-1:0] line_tag, f_line_tag;
    line_st_e         line_st, f_line_st;
    logic             acc_we, fill_we;
    line_st_e         acc_st, fill_st;

    // pending block table
    logic mshr_hit, mshr_merge, mshr_new, mshr_add, mshr_add_at;
    logic rel_found, rel_atomic;

    // miss queue
    logic [FREE_W-1:0]                 mq_free;
    logic [1:0]                        push_n;
    logic [MAX_PUSH-1:0][MREQ_W-1:0]   push_data;
    logic [MREQ_W-1:0]                 head_bits;
    mreq_t                             head;
    logic                              mq_pop;

    dcac_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst(rst),
        .rd_idx(req_idx), .rd_tag(line_tag), .rd_st(line_st),
        .acc_we(acc_we), .acc_tag(req_tag), .acc_st(acc_st),
        .f_idx(fill_idx), .f_tag(f_line_tag), .f_st(f_line_st),
        .fill_we(fill_we), .fill_st(fill_st)
    );

    dcac_mshr #(.N(MSHR_N), .MAXM(MSHR_MERGE), .BLK_W(BLK_W)) u_mshr (
        .clk(clk), .rst(rst),
        .probe_blk(req_blk), .probe_hit(mshr_hit),
        .can_merge(mshr_merge), .can_new(mshr_new),
        .add_en(mshr_add), .add_atomic(mshr_add_at),
        .rel_en(fill_valid), .rel_blk(fill_blk),
        .rel_found(rel_found), .rel_atomic(rel_atomic)
    );

    dcac_miss_fifo #(.DEPTH(MQ_DEPTH), .W(MREQ_W)) u_mq (
        .clk(clk), .rst(rst),
        .push_n(push_n), .push_data(push_data),
        .pop(mq_pop), .head(head_bits),
        .nonempty(mem_valid), .free_cnt(mq_free)
    );

    // fill completion
    assign fill_we = fill_valid && rel_found && (f_line_st == LN_PEND) && (f_line_tag == fill_tag);
    assign fill_st = rel_atomic ? LN_MOD : LN_VAL;

    // access decision
    logic  line_hit, pend_other, victim_dirty, fwd_write;
    logic  do_w, do_r, do_wb;
    rsp_e  code_d;
    mreq_t cand [MAX_PUSH];
    mreq_t slot [MAX_PUSH];
    logic [MAX_PUSH-1:0] cand_en;

    assign line_hit     = line_usable(line_st) && (line_tag == req_tag);
    assign pend_other   = (line_st == LN_PEND) && (line_tag != req_tag);
    assign victim_dirty = (line_st == LN_MOD);
    assign fwd_write    = req_write && (cfg_write_through || (cfg_private && req_global));

    always_comb begin
        code_d      = RSP_FAIL;
        do_w        = 1'b0;
        do_r        = 1'b0;
        do_wb       = 1'b0;
        acc_we      = 1'b0;
        acc_st      = LN_INV;
        mshr_add    = 1'b0;
        mshr_add_at = 1'b0;
        if (req_valid && !fill_valid) begin
            if (line_hit) begin
                if (fwd_write) begin
                    if (mq_free >= FREE_W'(1)) begin
                        code_d = RSP_HIT;
                        do_w   = 1'b1;
                        acc_we = 1'b1;
                        acc_st = LN_INV;
                    end
                end else begin
                    code_d = RSP_HIT;
                    if (req_write || req_atomic) begin
                        acc_we = 1'b1;
                        acc_st = LN_MOD;
                    end
                end
            end else if (!pend_other) begin
                if (req_write && !cfg_write_alloc) begin
                    if (mq_free >= FREE_W'(1)) begin
                        code_d = RSP_MISS;
                        do_w   = 1'b1;
                    end
                end else if ((mq_free >= FREE_W'(req_write ? 3 : 2)) &&
                             (mshr_merge || mshr_new)) begin
                    code_d      = RSP_MISS;
                    do_w        = req_write;
                    mshr_add    = 1'b1;
                    mshr_add_at = req_atomic && !req_write;
                    if (mshr_new) begin
                        do_r   = 1'b1;
                        do_wb  = victim_dirty;
                        acc_we = 1'b1;
                        acc_st = LN_PEND;
                    end
                end
            end
        end
    end

    // candidate requests in issue order: write, line read, writeback
    always_comb begin
        cand[0] = '{kind: MK_WRITE, addr: req_addr, bytes: req_bytes};
        cand[1] = '{kind: MK_READ, addr: {req_blk, {OFF_W{1'b0}}},
                    bytes: SIZE_W'(LINE_BYTES)};
        cand[2] = '{kind: MK_WBACK, addr: {line_tag, req_idx, {OFF_W{1'b0}}},
                    bytes: SIZE_W'(LINE_BYTES)};
        cand_en = {do_wb, do_r, do_w};
    end

    always_comb begin
        logic [1:0] n;
        n = 2'd0;
        for (int k = 0; k < MAX_PUSH; k++) slot[k] = '0;
        for (int k = 0; k < MAX_PUSH; k++) begin
            if (cand_en[k]) begin
                slot[n] = cand[k];
                n = n + 2'd1;
            end
        end
        push_n = n;
        for (int k = 0; k < MAX_PUSH; k++) push_data[k] = slot[k];
    end

    // memory side
    assign head      = mreq_t'(head_bits);
    assign mq_pop    = mem_valid && !mem_full;
    assign mem_kind  = head.kind;
    assign mem_addr  = head.addr;
    assign mem_bytes = head.bytes;

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid <= 1'b0;
            resp_code  <= RSP_HIT;
        end else begin
            resp_valid <= req_valid;
            resp_code  <= code_d;
        end
    end

    p_resp_follow_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> resp_valid);
    p_fill_fail_r12: assert property (@(posedge clk) disable iff (rst)
        (req_valid && fill_valid) |=> (resp_code == RSP_FAIL));
    p_port_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_full) |=> (mem_valid && $stable(mem_addr) && $stable(mem_kind)));

endmodule

// File: tb/test_dcache_access_ctrl.sv
module test_dcache_access_ctrl;
    localparam int DEPTH = 8;
    localparam int NENT  = 4;
    localparam int MAXM  = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_wt = 0, cfg_priv = 0, cfg_wa = 1;
    logic req_valid = 0, req_write = 0, req_atomic = 0, req_global = 0;
    logic [15:0] req_addr = '0, fill_addr = '0;
    logic [4:0]  req_bytes = 5'd4;
    logic fill_valid = 0, mem_full = 0;
    logic resp_valid, mem_valid;
    logic [1:0] resp_code, mem_kind;
    logic [15:0] mem_addr;
    logic [4:0]  mem_bytes;

    always #5 clk = ~clk;

    dcache_access_ctrl i_dcache_access_ctrl (
        .clk(clk), .rst(rst),
        .cfg_write_through(cfg_wt), .cfg_private(cfg_priv), .cfg_write_alloc(cfg_wa),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_atomic(req_atomic), .req_global(req_global), .req_bytes(req_bytes),
        .resp_valid(resp_valid), .resp_code(resp_code),
        .fill_valid(fill_valid), .fill_addr(fill_addr),
        .mem_valid(mem_valid), .mem_kind(mem_kind), .mem_addr(mem_addr),
        .mem_bytes(mem_bytes), .mem_full(mem_full)
    );

    int total = 0, bad = 0, cycles = 0;

    // reference model state
    typedef struct { int k; int a; int b; } mq_t;
    mq_t q[$];
    int  lt[8];
    int  ls[8];           // 0 invalid, 1 valid, 2 modified, 3 waiting
    int  mc[int];
    bit  ma[int];

    task automatic chk(string tag, int act, int exp, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // one clock: drive, predict, clock, compare
    task automatic cyc(string tag, bit rv, int a, bit w, bit at, bit gl, int by, bit fv, int fa);
        int code, free;
        req_valid = rv; req_addr = 16'(a); req_write = w; req_atomic = at;
        req_global = gl; req_bytes = 5'(by); fill_valid = fv; fill_addr = 16'(fa);
        code = 2;
        free = DEPTH - q.size();
        if (q.size() > 0 && !mem_full) void'(q.pop_front());
        if (fv) begin
            int fb = fa >> 4;
            if (mc.exists(fb)) begin
                int fi = fb & 7;
                if (ls[fi] == 3 && lt[fi] == (fb >> 3)) ls[fi] = ma[fb] ? 2 : 1;
                mc.delete(fb);
                ma.delete(fb);
            end
        end
        if (rv && !fv) begin
            int b = a >> 4;
            int i = b & 7;
            int t = b >> 3;
            bit hit = (ls[i] == 1 || ls[i] == 2) && lt[i] == t;
            if (hit) begin
                if (w && (cfg_wt || (cfg_priv && gl))) begin
                    if (free >= 1) begin q.push_back('{1, a, by}); ls[i] = 0; code = 0; end
                end else begin
                    code = 0;
                    if (w || at) ls[i] = 2;
                end
            end else if (!(ls[i] == 3 && lt[i] != t)) begin
                if (w && !cfg_wa) begin
                    if (free >= 1) begin q.push_back('{1, a, by}); code = 1; end
                end else begin
                    int need = w ? 3 : 2;
                    bit mrg = mc.exists(b) && mc[b] < MAXM;
                    bit nw  = !mc.exists(b) && mc.num() < NENT;
                    if (free >= need && (mrg || nw)) begin
                        code = 1;
                        if (w) q.push_back('{1, a, by});
                        if (mrg) begin
                            mc[b] = mc[b] + 1;
                            if (at && !w) ma[b] = 1;
                        end else begin
                            q.push_back('{2, a & 16'hFFF0, 16});
                            if (ls[i] == 2) q.push_back('{3, (lt[i] << 7) | (i << 4), 16});
                            ls[i] = 3; lt[i] = t; mc[b] = 1; ma[b] = at && !w;
                        end
                    end
                end
            end
        end
        @(posedge clk);
        @(negedge clk);
        chk(tag, resp_valid, rv, "resp_valid");
        if (rv) chk(tag, resp_code, code, "resp_code");
        chk("R11", mem_valid, q.size() > 0, "mem_valid");
        if (q.size() > 0) begin
            chk("R11", mem_kind, q[0].k, "mem_kind");
            chk("R11", mem_addr, q[0].a, "mem_addr");
            chk("R10", mem_bytes, q[0].b, "mem_bytes");
        end
        req_valid = 0; fill_valid = 0;
    endtask

    task automatic rd(string tag, int a, bit at = 0);
        cyc(tag, 1, a, 0, at, 1, 4, 0, 0);
    endtask
    task automatic wr(string tag, int a, bit gl = 1);
        cyc(tag, 1, a, 1, 0, gl, 4, 0, 0);
    endtask
    task automatic fill(string tag, int a);
        cyc(tag, 0, 0, 0, 0, 0, 0, 1, a);
    endtask
    task automatic idle(string tag, int n);
        for (int k = 0; k < n; k++) cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        while (cycles < 20000) begin
            @(posedge clk);
            cycles++;
        end
        bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int k = 0; k < 8; k++) begin lt[k] = 0; ls[k] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1", resp_valid, 0, "resp_valid after reset");
        chk("R1", mem_valid, 0, "mem_valid after reset");

        rd("R1", 16'h0010);
        idle("R10", 2);
        fill("R12", 16'h0010);
        rd("R3", 16'h0014);
        rd("R3", 16'h0018, 1);
        rd("R8", 16'h0090);
        fill("R12", 16'h0090);

        cfg_priv = 1;
        wr("R5", 16'h0094, 0);
        wr("R4", 16'h0098, 1);
        rd("R4", 16'h0090);
        fill("R12", 16'h0090);
        cfg_priv = 0; cfg_wt = 1;
        wr("R4", 16'h0090, 1);
        cfg_wt = 0;

        cfg_wa = 0;
        wr("R6", 16'h0200);
        rd("R6", 16'h0200);
        fill("R12", 16'h0200);
        cfg_wa = 1;
        wr("R5", 16'h0204);
        wr("R7", 16'h0280);
        fill("R12", 16'h0280);

        rd("R9", 16'h0300);
        rd("R9", 16'h0304);
        rd("R9", 16'h0308);
        rd("R9", 16'h0380);
        wr("R9", 16'h030C);
        fill("R12", 16'h0300);

        rd("R9", 16'h0400);
        rd("R9", 16'h0410);
        rd("R9", 16'h0420);
        rd("R9", 16'h0430);
        rd("R9", 16'h0440);
        idle("R11", 4);
        fill("R12", 16'h0400);
        fill("R12", 16'h0410);
        fill("R12", 16'h0420);
        fill("R12", 16'h0430);

        rd("R12", 16'h0500);
        cyc("R12", 1, 16'h0600, 0, 0, 1, 4, 1, 16'h0500);
        rd("R12", 16'h0700, 1);
        fill("R12", 16'h0700);
        rd("R12", 16'h0780);
        fill("R12", 16'h0780);
        idle("R11", 4);

        // headroom with a stalled port
        mem_full = 1;
        cfg_wa = 0;
        for (int k = 0; k < 6; k++) wr("R6", 16'h1000 + k * 16);
        cfg_wa = 1;
        wr("R7", 16'h1060);
        rd("R8", 16'h1070);
        rd("R8", 16'h1840);
        cfg_wa = 0;
        wr("R6", 16'h1850);
        cfg_wt = 1;
        wr("R4", 16'h0410);
        cfg_wt = 0;
        rd("R3", 16'h0414);
        for (int k = 0; k < 20; k++) begin
            mem_full = k[0];
            idle("R11", 1);
        end
        mem_full = 0;
        idle("R11", 6);
        fill("R12", 16'h1070);
        rd("R2", 16'h1074);
        idle("R2", 2);
        summary();
    end
endmodule